// File: doc/BRIEF.md
# Serial Multiplexer Channel Selector

This block sits on the device side of a serial link that programs an eight-way input multiplexer. A host opens a programming window by asserting a select line and clocks in a short word on a data line, one bit per rising edge of a shift clock. The block commits the channel only when the select line is released. The word carries an enable flag ahead of the channel number. When that flag is clear, or the word is incomplete, the channel that is already active stays in force. A host can therefore leave the data line low and keep working on the same input forever.

All three serial inputs are sampled by a faster local clock through a synchronizer of configurable depth. The edges of the select line and the shift clock are found in the local clock domain. The polarity of the select line is a parameter, because the line may be shared with a converter chip select either directly or through an inverter. Reset leaves every input disabled until the first accepted word arrives.

Top module: `chsel_mux_select`

## Requirements
- R1: While reset is held, and after it until the first accepted word, `chan_o` is 0 and `chan_valid_o` is 0. Once `chan_valid_o` is 1 it stays 1 until the next reset.
- R2: A bit on `mux_din` is captured on each rising edge of `mux_sck` seen while the select is active. The first captured bit is the enable flag. The next CHAN_W bits are the channel number, most significant bit first, and they map straight onto channel numbers 0 to 7.
- R3: `chan_o` and `chan_valid_o` change only on the deasserting edge of the select. A complete word with the enable flag at 1 then loads the channel number and sets `chan_valid_o` to 1. Neither output moves while the window is open.
- R4: A complete word with the enable flag at 0 leaves `chan_o` and `chan_valid_o` unchanged. This includes a word of all zeros.
- R5: A window that closes after fewer than CHAN_W+1 captured bits leaves both outputs unchanged.
- R6: Only the first CHAN_W+1 shift edges of a window are captured. Later edges in the same window are ignored.
- R7: With SEL_ACTIVE_HIGH=1 the select is active while `mux_sel` is 1. With SEL_ACTIVE_HIGH=0 it is active while `mux_sel` is 0. Behaviour is otherwise identical.
- R8: A shift edge seen in the same sampled cycle as select assertion is captured as the first bit of the new window. A shift edge seen in the same sampled cycle as select deassertion is not captured.
- R9: An accepted channel appears on the outputs at the (SYNC_STAGES+1)-th rising edge of `clk` after `mux_sel` changes. `rst_n` asserts asynchronously and is released through a two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mux_sck | input | 1 | Serial shift clock; bits are taken on its rising edge |
| mux_din | input | 1 | Serial programming data |
| mux_sel | input | 1 | Programming window select, polarity set by SEL_ACTIVE_HIGH |
| chan_o | output | CHAN_W | Active channel number |
| chan_valid_o | output | 1 | High once an enabled channel has been committed |

## Verification
Two pairs of events can meet in one sampled cycle. A window can open in the same cycle as a bit is captured, and a window can close in the same cycle as a shift edge arrives. The bench provokes both by changing `mux_sel` and `mux_sck` in the same local clock period. In the first case the word must count the coincident bit as its enable flag and commit the channel it names. In the second case the coincident fourth bit must be dropped, so the short word is rejected and the earlier channel stays. Both outcomes are checked at the ports of an active-high and an active-low instance. They are also compared on every clock against a behavioural reference model.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

  // Serial inputs after synchronization, bundled per sample.
  typedef struct packed {
    logic sel;   // select, normalized to active-high
    logic sck;   // shift clock level
    logic din;   // data level
  } chsel_in_t;

  localparam int unsigned CHSEL_IN_W = 3;

endpackage

// File: rtl/chsel_rst_sync.sv
module chsel_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);

  logic [1:0] rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 2'b00;
    end else begin
      rst_q <= {rst_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_q[1];

endmodule

// File: rtl/chsel_sync_bus.sv
module chsel_sync_bus #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = d_i;
    end else begin : g_next
      assign stage_d = stage_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[g] <= '0;
      end else begin
        stage_q[g] <= stage_d;
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/chsel_shift_capture.sv
module chsel_shift_capture #(
  parameter int unsigned CHAN_W = 3,
  localparam int unsigned WORD_W = CHAN_W + 1,
  localparam int unsigned CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              sck_i,
  input  logic              din_i,
  output logic [WORD_W-1:0] word_o,
  output logic              full_o,
  output logic              close_o
);

  logic              sel_q, sel_d;
  logic              sck_q, sck_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] word_q, word_d;

  logic              open_ev;
  logic              close_ev;
  logic              sck_edge;
  logic              take;
  logic [CNT_W-1:0]  cnt_base;
  logic [WORD_W-1:0] word_base;

  // Next-state logic
  always_comb begin
    open_ev   = sel_i & ~sel_q;
    close_ev  = ~sel_i & sel_q;
    sck_edge  = sck_i & ~sck_q;
    cnt_base  = open_ev ? '0 : cnt_q;
    word_base = open_ev ? '0 : word_q;
    take      = sel_i & sck_edge & (cnt_base < CNT_W'(WORD_W));
    cnt_d     = cnt_base + CNT_W'(take);
    word_d    = take ? {word_base[WORD_W-2:0], din_i} : word_base;
    sel_d     = sel_i;
    sck_d     = sck_i;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      sck_q  <= 1'b0;
      cnt_q  <= '0;
      word_q <= '0;
    end else begin
      sel_q  <= sel_d;
      sck_q  <= sck_d;
      cnt_q  <= cnt_d;
      word_q <= word_d;
    end
  end

  assign word_o  = word_q;
  assign full_o  = (cnt_q == CNT_W'(WORD_W));
  assign close_o = close_ev;

  // The bit count never passes the word length.
  assert_cnt_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(WORD_W))
    else $error("bit count above word length");

  // Nothing is captured while the window is closed.
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> ($stable(cnt_q) && $stable(word_q)))
    else $error("capture state moved with select inactive");

  // An opening window without a coincident shift edge starts empty.
  assert_open_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && !sel_q && !(sck_i && !sck_q)) |=> (cnt_q == '0))
    else $error("window did not start empty");

  // An opening window with a coincident shift edge starts with one bit.
  assert_open_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && !sel_q && sck_i && !sck_q) |=> (cnt_q == CNT_W'(1)))
    else $error("coincident first bit lost");

endmodule

// File: rtl/chsel_commit.sv
module chsel_commit #(
  parameter int unsigned CHAN_W = 3,
  localparam int unsigned WORD_W = CHAN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              close_i,
  input  logic              full_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [CHAN_W-1:0] chan_o,
  output logic              valid_o
);

  logic [CHAN_W-1:0] chan_q, chan_d;
  logic              valid_q, valid_d;
  logic              accept;

  // Next-state logic
  always_comb begin
    accept  = close_i & full_i & word_i[WORD_W-1];
    chan_d  = accept ? word_i[CHAN_W-1:0] : chan_q;
    valid_d = valid_q | accept;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      chan_q  <= chan_d;
      valid_q <= valid_d;
    end
  end

  assign chan_o  = chan_q;
  assign valid_o = valid_q;

  // Outputs only move on a window close.
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !close_i |=> ($stable(chan_q) && $stable(valid_q)))
    else $error("channel moved outside a close event");

  // Disabled or short words leave the channel alone.
  assert_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (close_i && !(full_i && word_i[WORD_W-1])) |=> ($stable(chan_q) && $stable(valid_q)))
    else $error("rejected word changed the channel");

  // An accepted word shows up on the next cycle.
  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (close_i && full_i && word_i[WORD_W-1]) |=> (valid_q && chan_q == $past(word_i[CHAN_W-1:0])))
    else $error("accepted word not loaded");

  // Valid is sticky until reset.
  assert_valid_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> valid_q)
    else $error("valid flag dropped");

endmodule

// File: rtl/chsel_mux_select.sv
module chsel_mux_select #(
  parameter int unsigned CHAN_W          = 3,
  parameter int unsigned SYNC_STAGES     = 2,
  parameter bit          SEL_ACTIVE_HIGH = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mux_sck,
  input  logic              mux_din,
  input  logic              mux_sel,
  output logic [CHAN_W-1:0] chan_o,
  output logic              chan_valid_o
);

  import chsel_pkg::*;

  localparam int unsigned WORD_W = CHAN_W + 1;

  logic              rst_int_n;
  logic              sel_norm;
  chsel_in_t         raw_in;
  chsel_in_t         sync_in;
  logic [WORD_W-1:0] word;
  logic              full;
  logic              close_ev;

  // Select polarity variant
  if (SEL_ACTIVE_HIGH) begin : g_sel_high
    assign sel_norm = mux_sel;
  end else begin : g_sel_low
    assign sel_norm = ~mux_sel;
  end

  assign raw_in = '{sel: sel_norm, sck: mux_sck, din: mux_din};

  chsel_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  chsel_sync_bus #(
    .WIDTH  (CHSEL_IN_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (raw_in),
    .q_o   (sync_in)
  );

  chsel_shift_capture #(
    .CHAN_W (CHAN_W)
  ) u_cap (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .sel_i   (sync_in.sel),
    .sck_i   (sync_in.sck),
    .din_i   (sync_in.din),
    .word_o  (word),
    .full_o  (full),
    .close_o (close_ev)
  );

  chsel_commit #(
    .CHAN_W (CHAN_W)
  ) u_commit (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .close_i (close_ev),
    .full_i  (full),
    .word_i  (word),
    .chan_o  (chan_o),
    .valid_o (chan_valid_o)
  );

  // Held reset forces the disabled state on the ports.
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_int_n |-> (chan_o == '0 && !chan_valid_o))
    else $error("outputs not cleared in reset");

endmodule

// File: tb/test_chsel_mux_select.sv
module test_chsel_mux_select;

  localparam int S = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic din = 1'b0;
  logic sel = 1'b0;
  logic [2:0] ch_h, ch_l;
  logic       v_h, v_l;

  int checks = 0;
  int bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  chsel_mux_select #(.CHAN_W(3), .SYNC_STAGES(S), .SEL_ACTIVE_HIGH(1'b1)) i_chsel_mux_select (
    .clk(clk), .rst_n(rst_n), .mux_sck(sck), .mux_din(din), .mux_sel(sel),
    .chan_o(ch_h), .chan_valid_o(v_h));

  chsel_mux_select #(.CHAN_W(3), .SYNC_STAGES(S), .SEL_ACTIVE_HIGH(1'b0)) i_chsel_mux_select_inv (
    .clk(clk), .rst_n(rst_n), .mux_sck(sck), .mux_din(din), .mux_sel(~sel),
    .chan_o(ch_l), .chan_valid_o(v_l));

  // Behavioural reference model: queues stand in for the sampling delay.
  bit qs[$], qk[$], qd[$];
  bit m_selp, m_sckp, m_valid;
  int m_cnt;
  bit [3:0] m_word;
  bit [2:0] m_chan;

  always @(posedge clk or negedge rst_n) begin : model
    bit ls, lk, ld;
    if (!rst_n) begin
      qs.delete(); qk.delete(); qd.delete();
      repeat (S) begin qs.push_back(1'b0); qk.push_back(1'b0); qd.push_back(1'b0); end
      m_selp = 0; m_sckp = 0; m_cnt = 0; m_word = 0; m_chan = 0; m_valid = 0;
    end else begin
      ls = qs[0]; lk = qk[0]; ld = qd[0];
      if (!ls && m_selp && m_cnt == 4 && m_word[3]) begin
        m_chan = m_word[2:0];
        m_valid = 1'b1;
      end
      if (ls && !m_selp) begin m_cnt = 0; m_word = 0; end
      if (ls && lk && !m_sckp && m_cnt < 4) begin
        m_word = {m_word[2:0], ld};
        m_cnt++;
      end
      m_selp = ls; m_sckp = lk;
      void'(qs.pop_front()); void'(qk.pop_front()); void'(qd.pop_front());
      qs.push_back(sel); qk.push_back(sck); qd.push_back(din);
    end
  end

  // Per-cycle comparison against the model (R9 timing, R7 both polarities).
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (ch_h !== m_chan || v_h !== m_valid || ch_l !== m_chan || v_l !== m_valid) begin
        bad++;
        $display("FAIL R9 cycle %0d: hi=%0d/%0b lo=%0d/%0b expected %0d/%0b",
                 cyc, ch_h, v_h, ch_l, v_l, m_chan, m_valid);
      end
    end
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      bad++;
      $display("FAIL R9 watchdog expired: actual=%0d cycles expected<=50000", cyc);
      finish_run();
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [2:0] ec, input logic ev);
    checks++;
    if (ch_h !== ec || v_h !== ev) begin
      bad++;
      $display("FAIL %s high-active: actual=%0d/%0b expected=%0d/%0b", tag, ch_h, v_h, ec, ev);
    end
    checks++;
    if (ch_l !== ec || v_l !== ev) begin
      bad++;
      $display("FAIL %s low-active (R7): actual=%0d/%0b expected=%0d/%0b", tag, ch_l, v_l, ec, ev);
    end
  endtask

  task automatic shift_bit(input logic b);
    din = b; wait_n(2);
    sck = 1'b1; wait_n(2);
    sck = 1'b0; wait_n(2);
  endtask

  // Bits sent MSB of 'bits' first, n of them.
  task automatic send(input int n, input logic [7:0] bits);
    sel = 1'b1; wait_n(2);
    for (int i = n - 1; i >= 0; i--) shift_bit(bits[i]);
    sel = 1'b0; wait_n(6);
  endtask

  logic [2:0] exp_c;

  initial begin
    wait_n(3);
    chk("R1 in reset", 3'd0, 1'b0);
    rst_n = 1'b1;
    wait_n(8);
    chk("R1 after reset", 3'd0, 1'b0);

    send(4, 8'b1101); exp_c = 3'd5;
    chk("R2 enabled ch5", exp_c, 1'b1);
    send(4, 8'b1010); exp_c = 3'd2;
    chk("R3 enabled ch2", exp_c, 1'b1);
    send(4, 8'b0111);
    chk("R4 disabled word", exp_c, 1'b1);
    send(4, 8'b0000);
    chk("R4 all zero word", exp_c, 1'b1);
    send(3, 8'b111);
    chk("R5 short word", exp_c, 1'b1);
    send(6, 8'b101111); exp_c = 3'd3;
    chk("R6 extra bits ignored", exp_c, 1'b1);

    // R3: open window holding a full word does not move the outputs.
    sel = 1'b1; wait_n(2);
    shift_bit(1'b1); shift_bit(1'b1); shift_bit(1'b1); shift_bit(1'b1);
    wait_n(4);
    chk("R3 hold while window open", exp_c, 1'b1);
    // R9: exact latency of the close.
    sel = 1'b0;
    wait_n(S);
    chk("R9 before commit edge", exp_c, 1'b1);
    wait_n(1);
    exp_c = 3'd7;
    chk("R9 at commit edge", exp_c, 1'b1);
    wait_n(4);

    send(4, 8'b1000); exp_c = 3'd0;
    chk("R2 enabled ch0", exp_c, 1'b1);

    // R8: shift edge coincident with window opening counts as first bit.
    din = 1'b1; sel = 1'b1; sck = 1'b1; wait_n(2);
    sck = 1'b0; wait_n(2);
    shift_bit(1'b1); shift_bit(1'b1); shift_bit(1'b0);
    sel = 1'b0; wait_n(6);
    exp_c = 3'd6;
    chk("R8 coincident open", exp_c, 1'b1);

    // R8: shift edge coincident with window closing is dropped.
    sel = 1'b1; wait_n(2);
    shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b0);
    din = 1'b1; wait_n(2);
    sck = 1'b1; sel = 1'b0; wait_n(2);
    sck = 1'b0; wait_n(6);
    chk("R8 coincident close", exp_c, 1'b1);

    send(4, 8'b1100); exp_c = 3'd4;
    chk("R2 enabled ch4", exp_c, 1'b1);

    // R1: a fresh reset clears the channel again.
    rst_n = 1'b0; wait_n(2);
    chk("R1 second reset", 3'd0, 1'b0);
    rst_n = 1'b1; wait_n(6);
    send(4, 8'b0001);
    chk("R4 disabled after reset", 3'd0, 1'b0);

    wait_n(4);
    finish_run();
  end

endmodule